// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill

This block refills one line of a 4-way, 128-set write-back data cache from a 64-bit memory bus. A miss request carries the missed byte address, the victim way chosen elsewhere, and a flag marking the access as non-cacheable. For a cacheable miss the block issues a burst read that starts at the double word holding the missed address. It then writes each of the four returned beats into the data array, wrapping the double-word index within the line. The first beat is the double word the load is waiting for. It goes to the load unit in the same cycle that it is written, so the load can complete while the rest of the line is still arriving.

The line's tag and valid bit are written only together with the last beat. The line is marked invalid as soon as the request is accepted, so a half-filled line never reads as valid. A non-cacheable request instead issues a single-beat read and forwards that one beat. It leaves the arrays untouched. A combinational read port exposes the data, tag and valid bit of any set, way and double word.

Top module: `line_fill_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, bus_req_o is 0, fwd_valid_o is 0, and every set/way reads rd_valid_o = 0.
- R2: A 32-bit byte address splits into double-word index addr[4:3], set index addr[11:5] and tag addr[31:12]. The tag array stores addr[31:12] for the filled set and way.
- R3: After a request is accepted, bus_req_o is raised on the next cycle and held until a cycle with bus_gnt_i = 1. While it is held, bus_addr_o equals the request address with bits [2:0] cleared. bus_burst_o is 1 for a cacheable request.
- R4: For a cacheable fill, the k-th data beat (k = 0..3, counting cycles with bus_dvalid_i = 1) is stored in double word (addr[4:3] + k) mod 4 of the addressed set and way. Idle cycles between beats are allowed.
- R5: fwd_valid_o is 1 for exactly one cycle per fill: the cycle of the first data beat. In that cycle fwd_data_o equals bus_data_i.
- R6: rd_valid_o for the target set/way is 0 from the cycle after acceptance until the last beat's clock edge. After that edge it is 1 with the new tag.
- R7: req_ready_o is 0 from acceptance until the edge of the last beat. A req_valid_i pulse during that time is ignored and changes no line.
- R8: With req_nc_i = 1, bus_burst_o is 0 and one beat completes the transfer. That beat is forwarded. The data, tag and valid bit of the addressed set/way keep their previous values.
- R9: A fill changes no other way of the same set.
- R10: rd_data_o, rd_tag_o and rd_valid_o follow rd_set_i, rd_way_i and rd_dw_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request valid |
| req_ready_o | output | 1 | Block idle, request accepted when valid |
| req_addr_i | input | 32 | Missed byte address |
| req_way_i | input | 2 | Way to refill |
| req_nc_i | input | 1 | Non-cacheable single-beat access |
| bus_req_o | output | 1 | Bus read request, held until grant |
| bus_gnt_i | input | 1 | Bus grant for the address phase |
| bus_addr_o | output | 32 | Critical double-word address |
| bus_burst_o | output | 1 | 1 = four-beat burst, 0 = single beat |
| bus_dvalid_i | input | 1 | Data beat valid |
| bus_data_i | input | 64 | Data beat |
| fwd_valid_o | output | 1 | Forwarded critical data valid |
| fwd_data_o | output | 64 | Forwarded critical double word |
| rd_set_i | input | 7 | Read port set |
| rd_way_i | input | 2 | Read port way |
| rd_dw_i | input | 2 | Read port double word |
| rd_data_o | output | 64 | Read data |
| rd_tag_o | output | 20 | Read tag |
| rd_valid_o | output | 1 | Read valid bit |

## Verification
On every cycle, the assertions check these rules: the forward pulse lasts one cycle and falls on a data beat, the bus request holds its address until granted, the block stays busy after acceptance, and tag writes happen only on data beats and never at acceptance. Only the bench scenarios can show the wrapped beat order for each of the four starting offsets and the final line contents and tags. They also show that non-cacheable accesses and stray requests during a fill leave lines intact, and that a half-filled line reads invalid.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } fill_state_e;
endpackage

// File: rtl/fill_seq.sv
module fill_seq
  import fill_pkg::*;
#(
  parameter int BEATS  = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_nc_i,
  input  logic [BEAT_W-1:0] crit_i,
  input  logic              bus_gnt_i,
  input  logic              bus_dvalid_i,
  output logic              req_ready_o,
  output logic              accept_o,
  output logic              bus_req_o,
  output logic              nc_o,
  output logic              beat_o,
  output logic              first_beat_o,
  output logic              last_beat_o,
  output logic [BEAT_W-1:0] beat_dw_o
);
  fill_state_e       state_q;
  logic [BEAT_W-1:0] cnt_q;
  logic              nc_q;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign accept_o     = req_ready_o && req_valid_i;
  assign bus_req_o    = (state_q == ST_ADDR);
  assign nc_o         = nc_q;
  assign beat_o       = (state_q == ST_DATA) && bus_dvalid_i;
  assign first_beat_o = beat_o && (cnt_q == '0);
  assign last_beat_o  = beat_o && (nc_q || (&cnt_q));
  // wraps modulo BEATS through the natural width
  assign beat_dw_o    = crit_i + cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      nc_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q <= ST_ADDR;
          nc_q    <= req_nc_i;
        end
        ST_ADDR: if (bus_gnt_i) begin
          state_q <= ST_DATA;
          cnt_q   <= '0;
        end
        ST_DATA: if (bus_dvalid_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_beat_o) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fill_data_array.sv
module fill_data_array #(
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int BEATS  = 4,
  parameter int DW     = 64,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int BEAT_W = $clog2(BEATS),
  localparam int DEPTH  = SETS * BEATS
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wset_i,
  input  logic [WAY_W-1:0]  wway_i,
  input  logic [BEAT_W-1:0] wdw_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [IDX_W-1:0]  rset_i,
  input  logic [WAY_W-1:0]  rway_i,
  input  logic [BEAT_W-1:0] rdw_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] bank_rd [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DW-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (wway_i == WAY_W'(w))) mem_q[{wset_i, wdw_i}] <= wdata_i;
    end
    assign bank_rd[w] = mem_q[{rset_i, rdw_i}];
  end

  assign rdata_o = bank_rd[rway_i];
endmodule

// File: rtl/fill_tag_array.sv
module fill_tag_array #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int LINES = SETS * WAYS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inval_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wset_i,
  input  logic [WAY_W-1:0] wway_i,
  input  logic [TAG_W-1:0] wtag_i,
  input  logic [IDX_W-1:0] rset_i,
  input  logic [WAY_W-1:0] rway_i,
  output logic [TAG_W-1:0] rtag_o,
  output logic             rvalid_o
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q;

  always_ff @(posedge clk_i) begin
    if (we_i) tag_q[{wset_i, wway_i}] <= wtag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (we_i) valid_q[{wset_i, wway_i}] <= 1'b1;
    else if (inval_i) valid_q[{wset_i, wway_i}] <= 1'b0;
  end

  assign rtag_o   = tag_q[{rset_i, rway_i}];
  assign rvalid_o = valid_q[{rset_i, rway_i}];
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 32,
  parameter int BUS_W      = 64,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int BEATS  = LINE_BYTES * 8 / BUS_W,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int BOFF_W = $clog2(BUS_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WAY_W-1:0]  req_way_i,
  input  logic              req_nc_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_burst_o,
  input  logic              bus_dvalid_i,
  input  logic [BUS_W-1:0]  bus_data_i,
  output logic              fwd_valid_o,
  output logic [BUS_W-1:0]  fwd_data_o,
  input  logic [IDX_W-1:0]  rd_set_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [BEAT_W-1:0] rd_dw_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_valid_o
);
  logic [ADDR_W-1:BOFF_W] lat_addr_q;
  logic [WAY_W-1:0]       lat_way_q;
  logic                   accept, nc, beat, first_beat, last_beat;
  logic [BEAT_W-1:0]      beat_dw;
  logic                   arr_we, tag_we, inval;

  wire [IDX_W-1:0]  lat_set = lat_addr_q[OFF_W+IDX_W-1:OFF_W];
  wire [TAG_W-1:0]  lat_tag = lat_addr_q[ADDR_W-1:OFF_W+IDX_W];
  wire [BEAT_W-1:0] lat_dw  = lat_addr_q[OFF_W-1:BOFF_W];
  wire [IDX_W-1:0]  req_set = req_addr_i[OFF_W+IDX_W-1:OFF_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_addr_q <= '0;
      lat_way_q  <= '0;
    end else if (accept) begin
      lat_addr_q <= req_addr_i[ADDR_W-1:BOFF_W];
      lat_way_q  <= req_way_i;
    end
  end

  fill_seq #(.BEATS(BEATS)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_nc_i     (req_nc_i),
    .crit_i       (lat_dw),
    .bus_gnt_i    (bus_gnt_i),
    .bus_dvalid_i (bus_dvalid_i),
    .req_ready_o  (req_ready_o),
    .accept_o     (accept),
    .bus_req_o    (bus_req_o),
    .nc_o         (nc),
    .beat_o       (beat),
    .first_beat_o (first_beat),
    .last_beat_o  (last_beat),
    .beat_dw_o    (beat_dw)
  );

  assign arr_we      = beat && !nc;
  assign tag_we      = last_beat && !nc;
  // drop the old line's valid bit at acceptance so a partial fill never hits
  assign inval       = accept && !req_nc_i;
  assign bus_addr_o  = {lat_addr_q, {BOFF_W{1'b0}}};
  assign bus_burst_o = !nc;
  assign fwd_valid_o = first_beat;
  assign fwd_data_o  = bus_data_i;

  fill_data_array #(
    .SETS(SETS), .WAYS(WAYS), .BEATS(BEATS), .DW(BUS_W)
  ) u_data (
    .clk_i   (clk_i),
    .we_i    (arr_we),
    .wset_i  (lat_set),
    .wway_i  (lat_way_q),
    .wdw_i   (beat_dw),
    .wdata_i (bus_data_i),
    .rset_i  (rd_set_i),
    .rway_i  (rd_way_i),
    .rdw_i   (rd_dw_i),
    .rdata_o (rd_data_o)
  );

  fill_tag_array #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)
  ) u_tag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inval_i  (inval),
    .we_i     (tag_we),
    .wset_i   (inval ? req_set : lat_set),
    .wway_i   (inval ? req_way_i : lat_way_q),
    .wtag_i   (lat_tag),
    .rset_i   (rd_set_i),
    .rway_i   (rd_way_i),
    .rtag_o   (rd_tag_o),
    .rvalid_o (rd_valid_o)
  );
endmodule

// File: rtl/line_fill_chk.sv
module line_fill_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_dvalid_i,
  input logic              fwd_valid_o,
  input logic              tag_we
);
  p_fwd_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |=> !fwd_valid_o);

  p_fwd_on_beat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (bus_dvalid_i && !req_ready_o));

  p_req_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o)));

  p_busy_after_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_bus_req_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !req_ready_o);

  p_tag_on_beat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we |-> (bus_dvalid_i && !req_ready_o && !bus_req_o));

  p_no_tag_at_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !tag_we);
endmodule

bind line_fill_ctrl line_fill_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .bus_req_o    (bus_req_o),
  .bus_gnt_i    (bus_gnt_i),
  .bus_addr_o   (bus_addr_o),
  .bus_dvalid_i (bus_dvalid_i),
  .fwd_valid_o  (fwd_valid_o),
  .tag_we       (tag_we)
);

// File: tb/line_fill_ctrl_tb.sv
`timescale 1ns/1ps
module line_fill_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_way_i = '0;
  logic        req_nc_i = 1'b0;
  logic        bus_req_o;
  logic        bus_gnt_i = 1'b0;
  logic [31:0] bus_addr_o;
  logic        bus_burst_o;
  logic        bus_dvalid_i = 1'b0;
  logic [63:0] bus_data_i = '0;
  logic        fwd_valid_o;
  logic [63:0] fwd_data_o;
  logic [6:0]  rd_set_i = '0;
  logic [1:0]  rd_way_i = '0;
  logic [1:0]  rd_dw_i = '0;
  logic [63:0] rd_data_o;
  logic [19:0] rd_tag_o;
  logic        rd_valid_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] exp_q[$];

  always #2.5 clk_i = ~clk_i;

  line_fill_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] beat_val(input logic [31:0] a, input int dw,
                                           input logic [7:0] seed);
    return {seed, a[31:5], 2'(dw), 27'(a[31:5]) ^ 27'h5a5a5a5};
  endfunction

  // scoreboard monitor: every forward pulse pops one expected word
  initial begin
    forever begin
      @(negedge clk_i); #2;
      if (rst_ni && fwd_valid_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected forward", fwd_data_o, '0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(fwd_data_o == e, "R5", "forwarded word", fwd_data_o, e);
        end
      end
    end
  end

  task automatic read_at(input logic [6:0] s, input logic [1:0] w, input logic [1:0] d);
    rd_set_i = s; rd_way_i = w; rd_dw_i = d; #0.2;
  endtask

  task automatic check_line(input logic [31:0] a, input logic [1:0] w,
                            input logic [7:0] seed, input string req);
    @(negedge clk_i); #0.5;
    for (int d = 0; d < 4; d++) begin
      read_at(a[11:5], w, 2'(d));
      chk(rd_data_o == beat_val(a, d, seed), req, "line data", rd_data_o, beat_val(a, d, seed));
    end
    chk(rd_valid_o == 1'b1, req, "valid after fill", 64'(rd_valid_o), 64'd1);
    chk(rd_tag_o == a[31:12], "R2", "tag", 64'(rd_tag_o), 64'(a[31:12]));
  endtask

  // driver + behavioural burst responder
  task automatic do_fill(input logic [31:0] a, input logic [1:0] w, input bit nc,
                         input logic [7:0] seed, input bit gaps, input bit stray,
                         input logic [31:0] stray_a);
    int crit = int'(a[4:3]);
    int nb   = nc ? 1 : 4;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R7", "ready before request", 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1; req_addr_i = a; req_way_i = w; req_nc_i = nc;
    @(negedge clk_i);
    req_valid_i = 1'b0; #1;
    chk(bus_req_o == 1'b1, "R3", "bus request raised", 64'(bus_req_o), 64'd1);
    chk(bus_addr_o == {a[31:3], 3'b0}, "R3", "critical address", 64'(bus_addr_o), 64'({a[31:3], 3'b0}));
    chk(bus_burst_o == !nc, nc ? "R8" : "R3", "burst flag", 64'(bus_burst_o), 64'(!nc));
    if (gaps) begin
      @(negedge clk_i); #1;
      chk(bus_req_o == 1'b1, "R3", "request held without grant", 64'(bus_req_o), 64'd1);
    end
    bus_gnt_i = 1'b1;
    @(negedge clk_i);
    bus_gnt_i = 1'b0;
    exp_q.push_back(beat_val(a, crit, seed));
    for (int k = 0; k < nb; k++) begin
      if (gaps && k == 2) begin
        bus_dvalid_i = 1'b0;
        @(negedge clk_i);
      end
      bus_dvalid_i = 1'b1;
      bus_data_i = beat_val(a, (crit + k) % 4, seed);
      if (stray && k == 1) begin
        req_valid_i = 1'b1; req_addr_i = stray_a; req_way_i = 2'd3; req_nc_i = 1'b0;
      end
      #1;
      chk(req_ready_o == 1'b0, "R7", "busy during beats", 64'(req_ready_o), 64'd0);
      if (!nc && k == 1) begin
        read_at(a[11:5], w, 2'd0);
        chk(rd_valid_o == 1'b0, "R6", "partial line invalid", 64'(rd_valid_o), 64'd0);
      end
      @(negedge clk_i);
      req_valid_i = 1'b0;
    end
    bus_dvalid_i = 1'b0;
    #1;
    chk(req_ready_o == 1'b1, "R7", "ready after last beat", 64'(req_ready_o), 64'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] a;
    repeat (3) @(negedge clk_i);
    #1;
    chk(req_ready_o == 1'b1, "R1", "ready in reset", 64'(req_ready_o), 64'd1);
    chk(bus_req_o == 1'b0, "R1", "no bus request in reset", 64'(bus_req_o), 64'd0);
    chk(fwd_valid_o == 1'b0, "R1", "no forward in reset", 64'(fwd_valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i); #0.5;
    for (int s = 0; s < 128; s += 37) begin
      read_at(7'(s), 2'(s % 4), 2'd0);
      chk(rd_valid_o == 1'b0, "R1", "line invalid after reset", 64'(rd_valid_o), 64'd0);
    end

    // every starting offset, R4 order checked via final contents
    for (int c = 0; c < 4; c++) begin
      a = {20'h3a000 + 20'(c), 7'(10 + c), 2'(c), 3'(c)};
      do_fill(a, 2'(c), 1'b0, 8'(8'h10 + c), c[0], 1'b0, '0);
      check_line(a, 2'(c), 8'(8'h10 + c), "R4");
    end

    // R9: another way of set 10 filled, way 0 untouched
    a = {20'h7f001, 7'd10, 2'd3, 3'd4};
    do_fill(a, 2'd2, 1'b0, 8'h55, 1'b0, 1'b0, '0);
    check_line(a, 2'd2, 8'h55, "R9");
    check_line({20'h3a000, 7'd10, 2'd0, 3'd0}, 2'd0, 8'h10, "R9");

    // R10: read port follows address changes combinationally
    @(negedge clk_i); #0.5;
    read_at(7'd11, 2'd1, 2'd2);
    chk(rd_data_o == beat_val({20'h3a001, 7'd11, 5'd0}, 2, 8'h11), "R10", "read mux",
        rd_data_o, beat_val({20'h3a001, 7'd11, 5'd0}, 2, 8'h11));
    read_at(7'd12, 2'd2, 2'd1);
    chk(rd_data_o == beat_val({20'h3a002, 7'd12, 5'd0}, 1, 8'h12), "R10", "read mux",
        rd_data_o, beat_val({20'h3a002, 7'd12, 5'd0}, 1, 8'h12));

    // R8: non-cacheable access to filled set/way leaves line intact
    do_fill({20'h11111, 7'd11, 2'd2, 3'd0}, 2'd1, 1'b1, 8'hee, 1'b0, 1'b0, '0);
    check_line({20'h3a001, 7'd11, 2'd1, 3'd1}, 2'd1, 8'h11, "R8");

    // R7: stray request during a fill is ignored
    a = {20'h22222, 7'd40, 2'd1, 3'd0};
    do_fill(a, 2'd0, 1'b0, 8'h77, 1'b1, 1'b1, {20'h33333, 7'd41, 5'd0});
    check_line(a, 2'd0, 8'h77, "R7");
    read_at(7'd41, 2'd3, 2'd0);
    chk(rd_valid_o == 1'b0, "R7", "stray request allocated nothing", 64'(rd_valid_o), 64'd0);
    chk(bus_req_o == 1'b0, "R7", "no bus request from stray", 64'(bus_req_o), 64'd0);

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R5", "all forwards seen", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule